// File: doc/BRIEF.md
# Numerically Controlled Sine Oscillator Core

This block is the digital heart of a direct digital synthesizer. A single reference clock drives a 32-bit phase accumulator, which gains the frequency tuning word on every cycle. The output frequency is therefore `ftw × f_clk / 2^32`. With a 125 MHz clock that gives a step of roughly 0.0291 Hz, and the highest usable tone is half the clock rate. A 5-bit phase offset is added at the most significant end of the phase. Its bits weigh 11.25°, 22.5°, 45°, 90° and 180° and may be combined freely. The 12-bit truncated phase is then turned into a 10-bit unsigned amplitude code that feeds an external DAC.

The tuning word, the phase offset and the power-down flag come from a double-buffered register outside the block, so they are treated as stable words. The amplitude is read from a quarter-wave table of 1024 magnitudes, which is filled at elaboration. The two top phase bits select the mirroring and the sign. Power-down freezes the accumulator and parks the output at mid-scale.

Top module: `nco_core`

## Requirements
- R1: While `pd_i` is low, every rising clock edge adds `ftw_i` to the 32-bit accumulator, modulo 2^32.
- R2: The table phase is `p = (acc[31:20] + pofs_i·128) mod 4096`. Offset bit 4 shifts by 180° and bit 0 shifts by 11.25°.
- R3: For a phase p, let `m = floor(511.5·|sin(2π(p+0.5)/4096)|)`. The amplitude is `512 + m` when p < 2048 and `511 − m` otherwise. The result is a 10-bit unsigned value from 0 to 1023.
- R4: An accumulator value (or an offset value) present just before clock edge k appears at `amp_o` after edge k+2. This makes three registers from the accumulator to the pin.
- R5: While `rst_i` is high on a clock edge, the accumulator clears to 0 and `amp_o` reads 512 after that edge.
- R6: An edge that samples `pd_i` high leaves the accumulator unchanged. After `pd_i` falls, the waveform continues from the held phase.
- R7: If `pd_i` is high at edge k, `amp_o` is 512 after edge k+2.
- R8: A tuning word of 2^31 gives the Nyquist pattern. From a cleared accumulator with zero offset, the output alternates between 512 and 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ftw_i | input | 32 | Frequency tuning word |
| pofs_i | input | 5 | Binary-weighted phase offset, added at the top of the phase |
| pd_i | input | 1 | Power-down: freezes the accumulator and parks the output at mid-scale |
| amp_o | output | 10 | Unsigned amplitude code for the DAC |

## Verification
A tuning word of one phase step per clock sweeps every table address in both half-waves. A design that mirrors the wrong quadrant, or that is off by one at the sign boundary (511 against 512), fails that sweep at once. All 32 phase offsets are applied with the accumulator at rest, which catches an offset added at the wrong bit position or without wrap. Power-down is toggled in bursts of one cycle and of several cycles. A design that lets the accumulator creep, or that aligns the mid-scale hold with the wrong pipeline stage, then shows a shifted waveform or a stray sample. Runs at Nyquist and with a negative step (wrap) expose carry and truncation mistakes.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int NCO_ACC_W   = 32;
    localparam int NCO_PHASE_W = 12;
    localparam int NCO_OFS_W   = 5;
    localparam int NCO_AMP_W   = 10;
endpackage

// File: rtl/nco_quadrant_fold.sv
module nco_quadrant_fold #(
    parameter int PHASE_W = 12,
    localparam int ADDR_W = PHASE_W - 2
) (
    input  logic [PHASE_W-1:0] phase_i,
    output logic [ADDR_W-1:0]  idx_o,
    output logic               neg_o
);
    // second and fourth quarters run the table backwards
    always_comb begin
        neg_o = phase_i[PHASE_W-1];
        if (phase_i[PHASE_W-2]) begin
            idx_o = ~phase_i[ADDR_W-1:0];
        end else begin
            idx_o = phase_i[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
    parameter int ADDR_W = 10,
    parameter int MAG_W  = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [MAG_W-1:0]  mag_o
);
    localparam real HALF_PI = 1.57079632679489661923;

    // magnitude at the centre of each quarter-wave bin, scaled to just below full range
    function automatic int quarter_mag(int k);
        real scale;
        real arg;
        scale = real'(1 << MAG_W) - 0.5;
        arg   = HALF_PI * (2.0 * real'(k) + 1.0) / real'(2 * DEPTH);
        return int'($floor(scale * $sin(arg)));
    endfunction

    logic [MAG_W-1:0] table_w [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        assign table_w[k] = MAG_W'(quarter_mag(k));
    end

    assign mag_o = table_w[addr_i];
endmodule

// File: rtl/nco_core.sv
module nco_core
    import nco_pkg::*;
#(
    parameter int ACC_W   = NCO_ACC_W,
    parameter int PHASE_W = NCO_PHASE_W,
    parameter int OFS_W   = NCO_OFS_W,
    parameter int AMP_W   = NCO_AMP_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ACC_W-1:0] ftw_i,
    input  logic [OFS_W-1:0] pofs_i,
    input  logic             pd_i,
    output logic [AMP_W-1:0] amp_o
);
    localparam int ADDR_W = PHASE_W - 2;
    localparam int MAG_W  = AMP_W - 1;
    localparam int PAD_W  = PHASE_W - OFS_W;
    localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

    typedef struct packed {
        logic [ACC_W-1:0]   acc;
        logic [PHASE_W-1:0] phase;
        logic               live1;
        logic [MAG_W-1:0]   mag;
        logic               neg2;
        logic               live2;
        logic [AMP_W-1:0]   amp;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [ADDR_W-1:0] idx_w;
    logic              neg_w;
    logic [MAG_W-1:0]  mag_w;
    logic [ACC_W-1:0]  acc_now;

    nco_quadrant_fold #(.PHASE_W(PHASE_W)) u_fold (
        .phase_i (st_q.phase),
        .idx_o   (idx_w),
        .neg_o   (neg_w)
    );

    nco_sine_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
        .addr_i (idx_w),
        .mag_o  (mag_w)
    );

    always_comb begin
        st_d = st_q;
        // stage 0: accumulate unless powered down
        if (!pd_i) begin
            st_d.acc = st_q.acc + ftw_i;
        end
        // stage 1: truncate and add the offset at the top bits
        st_d.phase = st_q.acc[ACC_W-1 -: PHASE_W] + {pofs_i, {PAD_W{1'b0}}};
        st_d.live1 = !pd_i;
        // stage 2: table lookup
        st_d.mag   = mag_w;
        st_d.neg2  = neg_w;
        st_d.live2 = st_q.live1;
        // stage 3: sign and offset-binary code
        if (!st_q.live2) begin
            st_d.amp = MID;
        end else if (st_q.neg2) begin
            st_d.amp = MID - AMP_W'(1) - AMP_W'(st_q.mag);
        end else begin
            st_d.amp = MID + AMP_W'(st_q.mag);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q     <= '0;
            st_q.amp <= MID;
        end else begin
            st_q <= st_d;
        end
    end

    assign amp_o   = st_q.amp;
    assign acc_now = st_q.acc;
endmodule

module nco_core_chk #(
    parameter int ACC_W = 32,
    parameter int AMP_W = 10
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [ACC_W-1:0] ftw_i,
    input logic             pd_i,
    input logic [AMP_W-1:0] amp_o,
    input logic [ACC_W-1:0] acc_now
);
    localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

    // R1
    acc_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !pd_i |=> acc_now == $past(acc_now) + $past(ftw_i));

    // R6
    acc_freeze_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pd_i |=> $stable(acc_now));

    // R7
    pd_midscale_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(pd_i, 3) |-> amp_o == MID);

    // R5
    rst_midscale_chk: assert property (@(posedge clk_i)
        rst_i |=> (amp_o == MID && acc_now == '0));

    // R3
    amp_known_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$isunknown(amp_o));
endmodule

bind nco_core nco_core_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ftw_i   (ftw_i),
    .pd_i    (pd_i),
    .amp_o   (amp_o),
    .acc_now (acc_now)
);

// File: tb/nco_core_tb.sv
`timescale 1ns/1ps
module nco_core_tb;
    localparam real PI = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ftw = '0;
    logic [4:0]  pofs = '0;
    logic        pd = 1'b0;
    logic [9:0]  amp;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R5";
    bit    done = 1'b0;

    // reference pipeline state
    logic [31:0] m_acc = '0;
    int          m_p1 = 512;
    int          m_p2 = 512;
    int          m_amp = 512;

    always #2.5 clk = ~clk;

    nco_core u_dut (
        .clk_i  (clk),
        .rst_i  (rst),
        .ftw_i  (ftw),
        .pofs_i (pofs),
        .pd_i   (pd),
        .amp_o  (amp)
    );

    function automatic int sine_ref(int p);
        real s;
        s = 511.5 * $sin(2.0 * PI * (real'(p) + 0.5) / 4096.0);
        if (p < 2048) return 512 + int'($floor(s));
        return 511 - int'($floor(-s));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_acc = '0;
            m_p1  = 512;
            m_p2  = 512;
            m_amp = 512;
        end else begin
            m_amp = m_p2;
            m_p2  = m_p1;
            if (pd) begin
                m_p1 = 512;
            end else begin
                m_p1 = sine_ref(int'((m_acc[31:20] + {pofs, 7'b0}) & 12'hFFF));
            end
            if (!pd) m_acc = m_acc + ftw;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        checks++;
        if (int'(amp) != m_amp) begin
            errors++;
            $display("FAIL %s amp=%0d expected=%0d at %0t", cur_req, amp, m_amp, $time);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cur_req = "R5";
        run(3);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R5: at rest after reset the output stays at mid-scale
        cur_req = "R5";
        run(6);

        // R2: every offset with the accumulator at rest
        cur_req = "R2";
        for (int o = 0; o < 32; o++) begin
            pofs = 5'(o);
            run(4);
        end
        pofs = '0;

        // R3 / R4: one phase step per clock, all table entries, both half-waves
        do_reset();
        cur_req = "R3";
        ftw = 32'h0010_0000;
        run(4100);

        // R1: fine-grained word, low accumulator bits carry into the phase
        cur_req = "R1";
        ftw  = 32'h0001_2345;
        pofs = 5'd5;
        run(800);

        // R4: offset changes while running, alignment with the pipeline
        cur_req = "R4";
        for (int o = 0; o < 12; o++) begin
            pofs = 5'(o * 3);
            run(2);
        end
        pofs = '0;

        // R8: Nyquist pattern from a cleared accumulator
        do_reset();
        cur_req = "R8";
        ftw = 32'h8000_0000;
        run(20);

        // R1: negative step, accumulator wraps downwards
        cur_req = "R1";
        ftw = 32'hFFF0_0000;
        run(300);

        // R6 / R7: power-down bursts of various lengths
        do_reset();
        ftw = 32'h0040_0000;
        run(10);
        for (int b = 1; b <= 8; b++) begin
            cur_req = "R7";
            pd = 1'b1;
            run(b);
            cur_req = "R6";
            pd = 1'b0;
            run(b + 2);
        end
        cur_req = "R7";
        pd = 1'b1;
        run(6);
        pd = 1'b0;
        cur_req = "R6";
        run(12);

        // R5: reset in the middle of a running tone
        ftw = 32'h0123_4567;
        run(20);
        do_reset();
        ftw = '0;
        cur_req = "R5";
        run(5);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule